// File: doc/BRIEF.md
# Out-of-Order ADD/MUL Issue and Execution Core

This block is the scheduling heart of a small dynamically scheduled processor with eight 16-bit registers. It accepts one decoded instruction per cycle through a valid/ready handshake. Each instruction is either an add or a multiply, with one destination and two source registers. The core renames the destination through an alias table and parks the instruction in a reservation station of its class: four adder stations and four multiplier stations. It waits there until both operands are known, then launches into a pipelined adder (six execute stages) or multiplier (eight execute stages).

Results return on one shared writeback bus. That bus is also the completion report to the surrounding pipeline. It carries the producing station's tag, the destination register and the value. Waiting stations pick operands off the bus. The alias table takes a value only if the register has not been renamed again since. The current architectural register values are visible as a flat output vector.

Top module: `ooo_core`

## Requirements
- R1: After reset no station is occupied, `in_ready` is 1 for both classes, `done_valid` is 0, and register Ri reads i+1 on `reg_vals` (bits 16*i+15 down to 16*i).
- R2: An add whose operands are available, accepted in cycle n, produces `done_valid` in cycle n+7 with the sum modulo 2^16. A multiply under the same conditions produces it in cycle n+9 with the low 16 bits of the product. `in_op` 0 selects add and 1 selects multiply.
- R3: A consumer of a register still pending from an earlier instruction starts executing no earlier than the cycle after that producer's writeback. An add accepted in cycle n+1 that reads the destination of an add accepted in cycle n completes in cycle n+14.
- R4: An instruction accepted in the very cycle its producer is on the writeback bus still takes the value from the bus and completes 7 cycles later (add).
- R5: `in_ready` is 0 while every station of the class selected by `in_op` is occupied, regardless of the other class. A station stays occupied until its own writeback cycle ends: with four adds accepted in cycles n to n+3, a fifth add is accepted in cycle n+8.
- R6: An instruction takes the lowest-numbered free station of its class. Adder stations carry tags 0 to 3 and multiplier stations carry tags 4 to 7, reported on `done_tag`.
- R7: When several stations of one class become ready in the same cycle, the one allocated earliest launches first and the others follow one per cycle.
- R8: When both units finish in the same cycle, the multiply result goes on the bus first and the add result follows in the next cycle.
- R9: A writeback never overwrites a register that a younger instruction has renamed. After a slow write and a later fast write to the same register, the register holds the younger value.
- R10: Every accepted instruction produces exactly one completion on `done_valid`, with its destination register on `done_dst` and its result on `done_val`.
- R11: `reg_vals` reflects each writeback to a register whose alias entry still names that producer, from the cycle after the writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered this cycle |
| in_ready | output | 1 | A station of the class chosen by in_op is free |
| in_op | input | 1 | 0 add, 1 multiply |
| in_dst | input | 3 | Destination register |
| in_src1 | input | 3 | First source register |
| in_src2 | input | 3 | Second source register |
| done_valid | output | 1 | Writeback bus active (one instruction completes) |
| done_tag | output | 3 | Station that produced the result |
| done_dst | output | 3 | Destination register of the completing instruction |
| done_val | output | 16 | Result value |
| reg_vals | output | 128 | Architectural register values, Ri in bits 16*i+15 down to 16*i |

## Verification
A corrupted station operand, tag or age entry surfaces at the ports as a wrong `done_val` or a completion in the wrong cycle. Timing is checked to the exact cycle, so a one-cycle slip in operand capture or launch order is caught at the first writeback of the affected instruction, 7 to 9 cycles after acceptance. A lost capture never launches and shows up as a missing completion. A broken alias-table guard leaves a stale value on `reg_vals` the cycle after the older writeback. A station held for the wrong time shows up as `in_ready` changing in the wrong cycle.

// File: rtl/ooo_pkg.sv
`timescale 1ns/100ps
package ooo_pkg;
  parameter int NREG    = 8;
  parameter int REG_W   = $clog2(NREG);
  parameter int DATA_W  = 16;
  parameter int NUM_ADD = 4;
  parameter int NUM_MUL = 4;
  parameter int TAG_W   = $clog2(NUM_ADD + NUM_MUL);
  parameter int ADD_LAT = 6;
  parameter int MUL_LAT = 8;

  typedef enum logic {OP_ADD = 1'b0, OP_MUL = 1'b1} op_e;

  typedef struct packed {
    logic              rdy;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] val;
  } opnd_t;
endpackage

// File: rtl/ooo_rat.sv
`timescale 1ns/100ps
module ooo_rat
  import ooo_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [REG_W-1:0]         rd_reg [2],
  output opnd_t                    rd_op  [2],
  input  logic                     ren_en,
  input  logic [REG_W-1:0]         ren_reg,
  input  logic [TAG_W-1:0]         ren_tag,
  input  logic                     bus_valid,
  input  logic [TAG_W-1:0]         bus_tag,
  input  logic [DATA_W-1:0]        bus_val,
  output logic [NREG*DATA_W-1:0]   arch_vals
);
  logic [NREG-1:0]   vld;
  logic [TAG_W-1:0]  tg [NREG];
  logic [DATA_W-1:0] vl [NREG];

  // operand lookup, with forwarding from the bus in the writeback cycle
  always_comb begin
    for (int p = 0; p < 2; p++) begin
      if (vld[rd_reg[p]]) begin
        rd_op[p].rdy = 1'b1;
        rd_op[p].tag = '0;
        rd_op[p].val = vl[rd_reg[p]];
      end else if (bus_valid && bus_tag == tg[rd_reg[p]]) begin
        rd_op[p].rdy = 1'b1;
        rd_op[p].tag = '0;
        rd_op[p].val = bus_val;
      end else begin
        rd_op[p].rdy = 1'b0;
        rd_op[p].tag = tg[rd_reg[p]];
        rd_op[p].val = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) begin
        vld[r] <= 1'b1;
        tg[r]  <= '0;
        vl[r]  <= DATA_W'(r + 1);
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (bus_valid && !vld[r] && tg[r] == bus_tag) begin
          vld[r] <= 1'b1;
          vl[r]  <= bus_val;
        end
      end
      if (ren_en) begin
        vld[ren_reg] <= 1'b0;
        tg[ren_reg]  <= ren_tag;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign arch_vals[g*DATA_W +: DATA_W] = vl[g];

    AST_KEEP_RENAME: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && !vld[g] && tg[g] != bus_tag) |=> $stable(vl[g])); // R9
  end
endmodule

// File: rtl/ooo_rs_bank.sv
`timescale 1ns/100ps
module ooo_rs_bank
  import ooo_pkg::*;
#(
  parameter int N        = 4,
  parameter int TAG_BASE = 0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              has_free,
  output logic [TAG_W-1:0]  free_tag,
  input  logic              alloc_en,
  input  opnd_t             alloc_s1,
  input  opnd_t             alloc_s2,
  input  logic [REG_W-1:0]  alloc_dst,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_val,
  input  logic              disp_en,
  output logic              disp_valid,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output logic [TAG_W-1:0]  disp_tag,
  output logic [REG_W-1:0]  disp_dst
);
  logic [N-1:0]     busy, issued, rdy_vec, sel, free_oh;
  opnd_t            s1 [N];
  opnd_t            s2 [N];
  logic [REG_W-1:0] dst [N];
  logic [N-1:0]     older [N];   // older[i][j]: i was allocated before j

  always_comb begin
    logic found;
    found   = 1'b0;
    free_oh = '0;
    for (int i = 0; i < N; i++) begin
      if (!busy[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign has_free = |free_oh;

  always_comb begin
    free_tag = '0;
    for (int i = 0; i < N; i++)
      if (free_oh[i]) free_tag = TAG_W'(TAG_BASE + i);
  end

  always_comb begin
    for (int i = 0; i < N; i++)
      rdy_vec[i] = busy[i] && !issued[i] && s1[i].rdy && s2[i].rdy;
  end

  // oldest ready entry wins
  always_comb begin
    for (int i = 0; i < N; i++) begin
      sel[i] = rdy_vec[i];
      for (int j = 0; j < N; j++)
        if (j != i && rdy_vec[j] && !older[i][j]) sel[i] = 1'b0;
    end
  end

  assign disp_valid = |sel;

  always_comb begin
    disp_a   = '0;
    disp_b   = '0;
    disp_tag = '0;
    disp_dst = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) begin
        disp_a   = s1[i].val;
        disp_b   = s2[i].val;
        disp_tag = TAG_W'(TAG_BASE + i);
        disp_dst = dst[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= '0;
      issued <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (busy[i] && bus_valid && !s1[i].rdy && s1[i].tag == bus_tag) begin
          s1[i].rdy <= 1'b1;
          s1[i].val <= bus_val;
        end
        if (busy[i] && bus_valid && !s2[i].rdy && s2[i].tag == bus_tag) begin
          s2[i].rdy <= 1'b1;
          s2[i].val <= bus_val;
        end
        if (busy[i] && bus_valid && bus_tag == TAG_W'(TAG_BASE + i)) begin
          busy[i]   <= 1'b0;
          issued[i] <= 1'b0;
        end
        if (disp_en && sel[i]) issued[i] <= 1'b1;
        if (alloc_en && free_oh[i]) begin
          busy[i]   <= 1'b1;
          issued[i] <= 1'b0;
          s1[i]     <= alloc_s1;
          s2[i]     <= alloc_s2;
          dst[i]    <= alloc_dst;
          older[i]  <= '0;
          for (int j = 0; j < N; j++)
            if (j != i) older[j][i] <= busy[j];
        end
      end
    end
  end

  AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel)); // R7

  for (genvar g = 0; g < N; g++) begin : g_chk
    AST_HELD_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (rst)
      (disp_en && sel[g]) |=> busy[g]); // R5
  end
endmodule

// File: rtl/ooo_exec_pipe.sv
`timescale 1ns/100ps
module ooo_exec_pipe
  import ooo_pkg::*;
#(
  parameter int LAT    = 6,
  parameter bit IS_MUL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              in_go,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [REG_W-1:0]  in_dst,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic [REG_W-1:0]  out_dst,
  output logic [DATA_W-1:0] out_val
);
  localparam int STG = LAT - 1;   // first execute stage is the launch cycle

  logic [STG-1:0]    v;
  logic [TAG_W-1:0]  t [STG];
  logic [REG_W-1:0]  d [STG];
  logic [DATA_W-1:0] r [STG];
  logic [DATA_W-1:0] res;

  if (IS_MUL) begin : g_mul
    assign res = in_a * in_b;
  end else begin : g_add
    assign res = in_a + in_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v <= '0;
    end else if (adv) begin
      v[0] <= in_go;
      t[0] <= in_tag;
      d[0] <= in_dst;
      r[0] <= res;
      for (int k = 1; k < STG; k++) begin
        v[k] <= v[k-1];
        t[k] <= t[k-1];
        d[k] <= d[k-1];
        r[k] <= r[k-1];
      end
    end
  end

  assign out_valid = v[STG-1];
  assign out_tag   = t[STG-1];
  assign out_dst   = d[STG-1];
  assign out_val   = r[STG-1];
endmodule

// File: rtl/ooo_core.sv
`timescale 1ns/100ps
module ooo_core
  import ooo_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_op,
  input  logic [REG_W-1:0]       in_dst,
  input  logic [REG_W-1:0]       in_src1,
  input  logic [REG_W-1:0]       in_src2,
  output logic                   done_valid,
  output logic [TAG_W-1:0]       done_tag,
  output logic [REG_W-1:0]       done_dst,
  output logic [DATA_W-1:0]      done_val,
  output logic [NREG*DATA_W-1:0] reg_vals
);
  op_e              op;
  logic             accept, add_alloc, mul_alloc;
  logic             add_free, mul_free;
  logic [TAG_W-1:0] add_ftag, mul_ftag, ren_tag;
  logic [REG_W-1:0] src_reg [2];
  opnd_t            src_op  [2];

  assign op        = op_e'(in_op);
  assign in_ready  = (op == OP_MUL) ? mul_free : add_free;
  assign accept    = in_valid && in_ready;
  assign add_alloc = accept && (op == OP_ADD);
  assign mul_alloc = accept && (op == OP_MUL);
  assign ren_tag   = (op == OP_MUL) ? mul_ftag : add_ftag;

  // lower-numbered register feeds slot 1, higher-numbered feeds slot 2
  assign src_reg[0] = (in_src1 <= in_src2) ? in_src1 : in_src2;
  assign src_reg[1] = (in_src1 <= in_src2) ? in_src2 : in_src1;

  ooo_rat rat_i (
    .clk(clk), .rst(rst),
    .rd_reg(src_reg), .rd_op(src_op),
    .ren_en(accept), .ren_reg(in_dst), .ren_tag(ren_tag),
    .bus_valid(done_valid), .bus_tag(done_tag), .bus_val(done_val),
    .arch_vals(reg_vals)
  );

  logic              add_dv, mul_dv, add_adv;
  logic [DATA_W-1:0] add_da, add_db, mul_da, mul_db;
  logic [TAG_W-1:0]  add_dt, mul_dt;
  logic [REG_W-1:0]  add_dd, mul_dd;

  logic              add_ov, mul_ov;
  logic [TAG_W-1:0]  add_ot, mul_ot;
  logic [REG_W-1:0]  add_od, mul_od;
  logic [DATA_W-1:0] add_oval, mul_oval;

  // adder holds (and stops launching) while the multiplier owns the bus
  assign add_adv = !(add_ov && mul_ov);

  ooo_rs_bank #(.N(NUM_ADD), .TAG_BASE(0)) add_rs_i (
    .clk(clk), .rst(rst),
    .has_free(add_free), .free_tag(add_ftag),
    .alloc_en(add_alloc), .alloc_s1(src_op[0]), .alloc_s2(src_op[1]), .alloc_dst(in_dst),
    .bus_valid(done_valid), .bus_tag(done_tag), .bus_val(done_val),
    .disp_en(add_adv), .disp_valid(add_dv),
    .disp_a(add_da), .disp_b(add_db), .disp_tag(add_dt), .disp_dst(add_dd)
  );

  ooo_rs_bank #(.N(NUM_MUL), .TAG_BASE(NUM_ADD)) mul_rs_i (
    .clk(clk), .rst(rst),
    .has_free(mul_free), .free_tag(mul_ftag),
    .alloc_en(mul_alloc), .alloc_s1(src_op[0]), .alloc_s2(src_op[1]), .alloc_dst(in_dst),
    .bus_valid(done_valid), .bus_tag(done_tag), .bus_val(done_val),
    .disp_en(1'b1), .disp_valid(mul_dv),
    .disp_a(mul_da), .disp_b(mul_db), .disp_tag(mul_dt), .disp_dst(mul_dd)
  );

  ooo_exec_pipe #(.LAT(ADD_LAT), .IS_MUL(1'b0)) add_pipe_i (
    .clk(clk), .rst(rst), .adv(add_adv), .in_go(add_dv),
    .in_a(add_da), .in_b(add_db), .in_tag(add_dt), .in_dst(add_dd),
    .out_valid(add_ov), .out_tag(add_ot), .out_dst(add_od), .out_val(add_oval)
  );

  ooo_exec_pipe #(.LAT(MUL_LAT), .IS_MUL(1'b1)) mul_pipe_i (
    .clk(clk), .rst(rst), .adv(1'b1), .in_go(mul_dv),
    .in_a(mul_da), .in_b(mul_db), .in_tag(mul_dt), .in_dst(mul_dd),
    .out_valid(mul_ov), .out_tag(mul_ot), .out_dst(mul_od), .out_val(mul_oval)
  );

  // registered writeback bus
  always_ff @(posedge clk) begin
    if (rst) begin
      done_valid <= 1'b0;
      done_tag   <= '0;
      done_dst   <= '0;
      done_val   <= '0;
    end else begin
      done_valid <= mul_ov || add_ov;
      if (mul_ov) begin
        done_tag <= mul_ot;
        done_dst <= mul_od;
        done_val <= mul_oval;
      end else if (add_ov) begin
        done_tag <= add_ot;
        done_dst <= add_od;
        done_val <= add_oval;
      end
    end
  end

  AST_MUL_FIRST: assert property (@(posedge clk) disable iff (rst)
    mul_ov |=> (done_valid && done_tag >= TAG_W'(NUM_ADD))); // R8
  AST_ADD_HELD: assert property (@(posedge clk) disable iff (rst)
    (add_ov && mul_ov) |=> (add_ov && $stable(add_ot))); // R8
endmodule

// File: tb/ooo_core_tb_top.sv
`timescale 1ns/100ps
module ooo_core_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_op = 1'b0;
  logic [2:0]   in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic         done_valid;
  logic [2:0]   done_tag, done_dst;
  logic [15:0]  done_val;
  logic [127:0] reg_vals;

  always #2.5 clk = ~clk;

  ooo_core dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .done_valid(done_valid), .done_tag(done_tag), .done_dst(done_dst),
    .done_val(done_val), .reg_vals(reg_vals)
  );

  typedef struct { logic [2:0] dst; logic [15:0] val; } exp_t;

  int          cyc = 0;
  int          n_chk = 0, n_err = 0;
  exp_t        sb[$];
  logic [15:0] model [8];
  int          done_cyc [8];
  int          done_tg  [8];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rv(input int r);
    return int'(reg_vals[r*16 +: 16]);
  endfunction

  // monitor: every completion must match an outstanding expected item
  bit mon_hit;
  int mon_exp;
  always @(negedge clk) begin
    if (!rst && done_valid) begin
      mon_hit = 1'b0;
      mon_exp = (sb.size() > 0) ? int'(sb[0].val) : 0;
      for (int k = 0; k < sb.size(); k++) begin
        if (!mon_hit && sb[k].dst == done_dst && sb[k].val == done_val) begin
          sb.delete(k);
          mon_hit = 1'b1;
        end
      end
      chk(mon_hit, "R10", "completion matches an issued instruction", int'(done_val), mon_exp);
      done_cyc[done_dst] = cyc;
      done_tg[done_dst]  = int'(done_tag);
    end
  end

  // driver: offers one instruction, returns its acceptance cycle
  task automatic issue(input bit op, input int d, input int a, input int b,
                       input int at, output int acc);
    logic [15:0] r;
    @(negedge clk);
    while (cyc < at) @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    in_dst   = 3'(d);
    in_src1  = 3'(a);
    in_src2  = 3'(b);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    acc = cyc;
    r = op ? 16'(model[a] * model[b]) : 16'(model[a] + model[b]);
    model[d] = r;
    sb.push_back('{3'(d), r});
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    int w;
    w = 0;
    while (sb.size() != 0 && w < 2000) begin
      @(negedge clk);
      w++;
    end
    chk(sb.size() == 0, "R10", "all issued instructions completed", sb.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int n, m, c, q;
    for (int r = 0; r < 8; r++) model[r] = 16'(r + 1);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(in_ready == 1'b1, "R1", "in_ready after reset (add)", int'(in_ready), 1);
    chk(done_valid == 1'b0, "R1", "done_valid after reset", int'(done_valid), 0);
    for (int r = 0; r < 8; r++)
      chk(rv(r) == r + 1, "R1", "register reset value", rv(r), r + 1);

    // R2 / R6: lone add and lone multiply
    issue(1'b0, 3, 1, 2, 0, n);
    drain();
    chk(done_cyc[3] == n + 7, "R2", "add completion cycle", done_cyc[3], n + 7);
    chk(done_tg[3] == 0, "R6", "first add uses station tag 0", done_tg[3], 0);
    issue(1'b1, 4, 2, 3, 0, n);
    drain();
    chk(done_cyc[4] == n + 9, "R2", "mul completion cycle", done_cyc[4], n + 9);
    chk(done_tg[4] == 4, "R6", "first mul uses station tag 4", done_tg[4], 4);
    chk(rv(3) == int'(model[3]), "R11", "R3 visible after writeback", rv(3), int'(model[3]));
    chk(rv(4) == int'(model[4]), "R11", "R4 visible after writeback", rv(4), int'(model[4]));

    // R3: dependent add waits for producer writeback
    issue(1'b0, 5, 3, 4, 0, n);
    issue(1'b0, 6, 5, 5, 0, m);
    drain();
    chk(m == n + 1, "R3", "consumer accepted back to back", m, n + 1);
    chk(done_cyc[6] == n + 14, "R3", "dependent add completion cycle", done_cyc[6], n + 14);

    // R4: consumer accepted during producer writeback
    issue(1'b0, 1, 6, 7, 0, n);
    issue(1'b0, 2, 1, 0, n + 7, m);
    drain();
    chk(m == n + 7, "R4", "consumer accepted in writeback cycle", m, n + 7);
    chk(done_cyc[2] == n + 14, "R4", "forwarded consumer completion", done_cyc[2], n + 14);

    // R8: simultaneous finish, multiply first
    issue(1'b1, 7, 0, 1, 0, n);
    issue(1'b0, 0, 2, 3, n + 2, m);
    drain();
    chk(done_cyc[7] == n + 9, "R8", "mul takes the bus first", done_cyc[7], n + 9);
    chk(done_cyc[0] == n + 10, "R8", "add follows one cycle later", done_cyc[0], n + 10);

    // R5: adder stations full, multiplier unaffected
    issue(1'b0, 1, 5, 6, 0, n);
    issue(1'b0, 2, 5, 6, 0, q);
    issue(1'b0, 3, 5, 6, 0, q);
    issue(1'b0, 4, 5, 6, 0, q);
    @(negedge clk);
    in_op = 1'b0;
    #1;
    chk(in_ready == 1'b0, "R5", "in_ready low with all adder stations busy", int'(in_ready), 0);
    in_op = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R5", "in_ready high for multiply meanwhile", int'(in_ready), 1);
    issue(1'b0, 5, 6, 7, 0, m);
    drain();
    chk(m == n + 8, "R5", "fifth add accepted after first writeback", m, n + 8);
    chk(done_tg[5] == 0, "R6", "freed lowest station reused", done_tg[5], 0);

    // R9: slow older write and fast younger write to one register
    issue(1'b1, 5, 2, 2, 0, n);
    issue(1'b0, 5, 1, 1, 0, m);
    drain();
    chk(done_cyc[5] == n + 9, "R9", "older multiply completes last", done_cyc[5], n + 9);
    chk(rv(5) == int'(model[5]), "R9", "register keeps younger value", rv(5), int'(model[5]));

    // R7: older station in higher index launches first
    issue(1'b0, 0, 4, 4, 0, n);
    issue(1'b1, 1, 2, 3, 0, q);
    issue(1'b0, 6, 1, 5, 0, q);
    issue(1'b0, 7, 1, 1, n + 8, c);
    drain();
    chk(c == n + 8, "R7", "younger add accepted in cycle n+8", c, n + 8);
    chk(done_tg[7] == 0, "R6", "younger add placed in station tag 0", done_tg[7], 0);
    chk(done_tg[6] == 1, "R6", "older add placed in station tag 1", done_tg[6], 1);
    chk(done_cyc[6] == n + 17, "R7", "older add completes first", done_cyc[6], n + 17);
    chk(done_cyc[7] == n + 18, "R7", "younger add one cycle later", done_cyc[7], n + 18);

    // R11: final architectural state
    for (int r = 0; r < 8; r++)
      chk(rv(r) == int'(model[r]), "R11", "final register value", rv(r), int'(model[r]));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule